// File: doc/BRIEF.md
# Selector-Indexed Configuration Read Port

This block lets a host read a table of byte-string configuration items through a couple of bus registers. The host first writes a 16-bit selector naming one item. The selector write also rewinds the read position to the start of that item. Each data read then returns the next bytes of the item and moves the position past them. Once the item runs out, reads return zero.

The selector holds a bank flag in bit 15 and an entry index in bits 13:0. There are two banks: a common bank and an architecture-local bank. Each bank keeps its own array of entries. Each entry has a length and up to `MAX_LEN` bytes. The store is filled through a separate load port before the host starts reading.

A parameter chooses between two address layouts:
- **Split layout:** separate control and data registers. The data register can be widened to up to four bytes per access.
- **Combined layout:** a single window that carries both the selector and the byte-wide data register.

Top module: `cfg_read_port`

## Requirements
- R1: An accepted selector write loads the selector from `bus_wdata[15:0]` and sets the read offset of the selected item to zero, whether the item was selected before or not.
- R2: Selector bit 15 picks the bank (0 common, 1 architecture-local). Bits 13:0 are the entry index. Bit 14 is ignored.
- R3: An accepted data read of N bytes returns, one cycle later on `bus_rdata`, the next N item bytes. The first byte sits in bits 8N-1:8N-8 and the last byte in bits 7:0. Bits above 8N are zero. Bytes past the end of the item read as zero. The offset advances by the number of item bytes actually returned.
- R4: A data read at or past the item length, or from an entry of length 0, returns zero and leaves the offset unchanged.
- R5: Reset makes `bus_rdata` zero and selects entry 0 of the common bank at offset 0.
- R6: A selector whose masked index is `NUM_ENTRIES` or above makes every data read return zero until the next accepted selector write. Index `NUM_ENTRIES-1` stays valid.
- R7: Data writes are accepted but change neither item contents, nor offset, nor selector.
- R8: In the split layout (`COMBINED=0`), address 0 is the control register and accepts only 2-byte writes. Address 1 is the data register and accepts reads and writes of 1 to `DATA_BYTES` bytes. Every other combination is rejected.
- R9: In the combined layout (`COMBINED=1`), a 2-byte write at either address is a selector write. A 1-byte access at address 0 is a data access. Every other combination is rejected.
- R10: A rejected read returns zero. A rejected access of either kind leaves selector and offset unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | Register address within the window |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data; the selector is taken from bits 15:0 |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read |
| ld_we | input | 1 | Load one item byte |
| ld_len_we | input | 1 | Load one item length |
| ld_bank | input | 1 | Bank of the entry being loaded |
| ld_entry | input | EW = clog2(NUM_ENTRIES) | Entry being loaded |
| ld_off | input | clog2(MAX_LEN) | Byte position being loaded |
| ld_byte | input | 8 | Byte value to load |
| ld_len | input | clog2(MAX_LEN+1) | Length value to load |

## Verification
The bench aims at the edges of an item:
- **Wide read crossing the end.** A design that pads on the wrong side, or advances by the full access size, shows up when the next read returns nonzero or misaligned bytes.
- **Exhausted, empty and invalid entries.** These must read zero. The first index past the limit and the last valid index are both exercised, so an off-by-one in the limit check reads data where zero is due, or zero where data is due.
- **Rejected and ignored accesses.** Each one is followed by a read that continues the same item, so a stray offset change or reselection is visible.
- **Bank bit and masked bit 14.** Both are exercised. So are a reset in the middle of an item and the combined-window decode.

// File: rtl/cfg_read_port.sv
module cfg_read_port #(
  parameter int NUM_ENTRIES = 8,
  parameter int MAX_LEN     = 16,
  parameter int DATA_BYTES  = 1,
  parameter bit COMBINED    = 1'b0,
  localparam int EW = $clog2(NUM_ENTRIES),
  localparam int OW = $clog2(MAX_LEN),
  localparam int LW = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_valid,
  input  logic          bus_we,
  input  logic          bus_addr,
  input  logic [2:0]    bus_size,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          ld_we,
  input  logic          ld_len_we,
  input  logic          ld_bank,
  input  logic [EW-1:0] ld_entry,
  input  logic [OW-1:0] ld_off,
  input  logic [7:0]    ld_byte,
  input  logic [LW-1:0] ld_len
);
  localparam int SLOTS = 2 * NUM_ENTRIES;
  localparam int DEPTH = SLOTS * MAX_LEN;
  localparam int AW    = $clog2(DEPTH);
  localparam int PW    = LW + 3;

  logic [7:0]    mem  [DEPTH];
  logic [LW-1:0] lens [SLOTS];

  logic [15:0]   sel_q;
  logic          inv_q;
  logic [LW-1:0] off_q;
  logic [31:0]   rdata_q;

  logic sel_wr, dat_acc;

  generate
    if (COMBINED) begin : g_comb
      assign sel_wr  = bus_valid & bus_we & (bus_size == 3'd2);
      assign dat_acc = bus_valid & (bus_size == 3'd1) & ~bus_addr;
    end else begin : g_split
      assign sel_wr  = bus_valid & bus_we & ~bus_addr & (bus_size == 3'd2);
      assign dat_acc = bus_valid & bus_addr & (bus_size != 3'd0) &
                       (bus_size <= 3'(DATA_BYTES));
    end
  endgenerate

  wire rd_acc  = dat_acc & ~bus_we;
  wire data_wr = dat_acc & bus_we;

  wire [EW:0]    slot    = {sel_q[15], sel_q[EW-1:0]};
  wire [LW-1:0]  cur_len = lens[slot];
  wire [AW-1:0]  base    = AW'(slot) * AW'(MAX_LEN);
  wire [AW-1:0]  ld_addr = AW'({ld_bank, ld_entry}) * AW'(MAX_LEN) + AW'(ld_off);
  wire           new_inv = bus_wdata[13:0] >= 14'(NUM_ENTRIES);

  logic [31:0]   pack;
  logic [2:0]    adv;
  logic [PW-1:0] pos;
  logic          ok;

  always_comb begin
    pack = '0;
    adv  = '0;
    pos  = '0;
    ok   = 1'b0;
    for (int k = 0; k < 4; k++) begin
      pos = PW'(off_q) + PW'(k);
      ok  = ~inv_q && (pos < PW'(cur_len));
      if (3'(k) < bus_size) begin
        pack = {pack[23:0], ok ? mem[base + AW'(pos)] : 8'h00};
        if (ok) adv = adv + 3'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ld_we)     mem[ld_addr]                <= ld_byte;
    if (ld_len_we) lens[{ld_bank, ld_entry}]  <= ld_len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      inv_q   <= 1'b0;
      off_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (sel_wr) begin
        sel_q <= bus_wdata[15:0];
        inv_q <= new_inv;
        off_q <= '0;
      end else if (rd_acc) begin
        off_q <= off_q + LW'(adv);
      end
      if (bus_valid && !bus_we) rdata_q <= rd_acc ? pack : 32'h0;
    end
  end

  assign bus_rdata = rdata_q;

  a_r1_sel_rewinds: assert property (@(posedge clk) disable iff (rst)
    sel_wr |=> (off_q == '0));

  a_r6_invalid_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_acc && inv_q) |=> (bus_rdata == 32'h0) && $stable(off_q));

  a_r7_write_ignored: assert property (@(posedge clk) disable iff (rst)
    data_wr |=> $stable(off_q) && $stable(sel_q) && $stable(inv_q));

  a_r10_reject_holds: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !sel_wr && !dat_acc) |=> $stable(off_q) && $stable(sel_q));

  a_r10_reject_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_we && !dat_acc) |=> (bus_rdata == 32'h0));

  a_r3_advance_bounded: assert property (@(posedge clk) disable iff (rst)
    rd_acc |=> ((off_q - $past(off_q)) <= LW'($past(bus_size))));

endmodule

// File: tb/cfg_read_port_tb_top.sv
module cfg_read_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 8;
  localparam int ML = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        s_valid = 0, s_we = 0, s_addr = 0;
  logic [2:0]  s_size = 0;
  logic [31:0] s_wdata = 0, s_rdata;
  logic        c_valid = 0, c_we = 0, c_addr = 0;
  logic [2:0]  c_size = 0;
  logic [31:0] c_wdata = 0, c_rdata;
  logic        ld_we = 0, ld_len_we = 0, ld_bank = 0;
  logic [2:0]  ld_entry = 0;
  logic [3:0]  ld_off = 0;
  logic [7:0]  ld_byte = 0;
  logic [4:0]  ld_len = 0;

  int n_run = 0;
  int n_fail = 0;

  cfg_read_port #(.NUM_ENTRIES(NE), .MAX_LEN(ML), .DATA_BYTES(4), .COMBINED(1'b0)) dut_i (
    .clk(clk), .rst(rst), .bus_valid(s_valid), .bus_we(s_we), .bus_addr(s_addr),
    .bus_size(s_size), .bus_wdata(s_wdata), .bus_rdata(s_rdata),
    .ld_we(ld_we), .ld_len_we(ld_len_we), .ld_bank(ld_bank), .ld_entry(ld_entry),
    .ld_off(ld_off), .ld_byte(ld_byte), .ld_len(ld_len));

  cfg_read_port #(.NUM_ENTRIES(NE), .MAX_LEN(ML), .DATA_BYTES(1), .COMBINED(1'b1)) dut_c_i (
    .clk(clk), .rst(rst), .bus_valid(c_valid), .bus_we(c_we), .bus_addr(c_addr),
    .bus_size(c_size), .bus_wdata(c_wdata), .bus_rdata(c_rdata),
    .ld_we(ld_we), .ld_len_we(ld_len_we), .ld_bank(ld_bank), .ld_entry(ld_entry),
    .ld_off(ld_off), .ld_byte(ld_byte), .ld_len(ld_len));

  typedef struct packed {
    logic        we;
    logic        addr;
    logic [2:0]  size;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 3'd4, 32'h0,    32'h00010203, 4'd5},  // R5 item 0 after reset
    '{1'b0, 1'b1, 3'd1, 32'h0,    32'h00000000, 4'd4},  // R4 exhausted
    '{1'b1, 1'b0, 3'd2, 32'h0001, 32'h0,        4'd1},
    '{1'b0, 1'b1, 3'd2, 32'h0,    32'h00001011, 4'd3},
    '{1'b0, 1'b1, 3'd2, 32'h0,    32'h00001213, 4'd3},
    '{1'b0, 1'b1, 3'd4, 32'h0,    32'h14000000, 4'd3},  // R3 right pad
    '{1'b0, 1'b1, 3'd4, 32'h0,    32'h00000000, 4'd4},
    '{1'b1, 1'b0, 3'd2, 32'h0001, 32'h0,        4'd1},  // R1 reselect rewinds
    '{1'b0, 1'b1, 3'd1, 32'h0,    32'h00000010, 4'd1},
    '{1'b1, 1'b1, 3'd4, 32'hFFFFFFFF, 32'h0,    4'd7},  // R7 data write
    '{1'b0, 1'b1, 3'd3, 32'h0,    32'h00111213, 4'd7},
    '{1'b1, 1'b0, 3'd2, 32'h8001, 32'h0,        4'd2},
    '{1'b0, 1'b1, 3'd4, 32'h0,    32'h90919200, 4'd2},  // R2 local bank
    '{1'b1, 1'b0, 3'd2, 32'h0002, 32'h0,        4'd4},
    '{1'b0, 1'b1, 3'd4, 32'h0,    32'h00000000, 4'd4},  // R4 empty entry
    '{1'b1, 1'b0, 3'd2, 32'h0008, 32'h0,        4'd6},
    '{1'b0, 1'b1, 3'd4, 32'h0,    32'h00000000, 4'd6},  // R6 first invalid index
    '{1'b0, 1'b1, 3'd1, 32'h0,    32'h00000000, 4'd6},
    '{1'b1, 1'b0, 3'd2, 32'h4001, 32'h0,        4'd2},
    '{1'b0, 1'b1, 3'd2, 32'h0,    32'h00001011, 4'd2},  // R2 bit 14 masked
    '{1'b1, 1'b0, 3'd4, 32'h0003, 32'h0,        4'd8},  // R8 4-byte ctl write
    '{1'b0, 1'b1, 3'd2, 32'h0,    32'h00001213, 4'd8},
    '{1'b0, 1'b0, 3'd2, 32'h0,    32'h00000000, 4'd10}, // R10 ctl read
    '{1'b0, 1'b1, 3'd1, 32'h0,    32'h00000014, 4'd10},
    '{1'b1, 1'b0, 3'd2, 32'h0003, 32'h0,        4'd1},
    '{1'b0, 1'b1, 3'd5, 32'h0,    32'h00000000, 4'd8},  // R8 too wide
    '{1'b0, 1'b1, 3'd4, 32'h0,    32'h30313233, 4'd3},
    '{1'b0, 1'b1, 3'd4, 32'h0,    32'h34353637, 4'd3},
    '{1'b0, 1'b1, 3'd4, 32'h0,    32'h38393A3B, 4'd3},
    '{1'b0, 1'b1, 3'd4, 32'h0,    32'h3C3D3E3F, 4'd3},
    '{1'b0, 1'b1, 3'd1, 32'h0,    32'h00000000, 4'd4},  // R4 after full length
    '{1'b1, 1'b0, 3'd2, 32'h8000, 32'h0,        4'd2},
    '{1'b0, 1'b1, 3'd2, 32'h0,    32'h00008081, 4'd2},
    '{1'b1, 1'b0, 3'd2, 32'h0007, 32'h0,        4'd6},
    '{1'b0, 1'b1, 3'd2, 32'h0,    32'h00007000, 4'd6},  // R6 last valid index
    '{1'b0, 1'b1, 3'd0, 32'h0,    32'h00000000, 4'd8}   // R8 zero size
  };

  function automatic int item_len(input bit b, input int e);
    if (!b) return (e == 0) ? 4 : (e == 1) ? 5 : (e == 3) ? 16 : (e == 7) ? 1 : 0;
    return (e == 0) ? 2 : (e == 1) ? 3 : 0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic s_op(input logic we, input logic a, input logic [2:0] sz, input logic [31:0] wd);
    @(negedge clk);
    s_valid = 1'b1; s_we = we; s_addr = a; s_size = sz; s_wdata = wd;
    @(posedge clk); #1;
    s_valid = 1'b0;
  endtask

  task automatic c_op(input logic we, input logic a, input logic [2:0] sz, input logic [31:0] wd);
    @(negedge clk);
    c_valid = 1'b1; c_we = we; c_addr = a; c_size = sz; c_wdata = wd;
    @(posedge clk); #1;
    c_valid = 1'b0;
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R5 split rdata at reset", s_rdata, 32'h0);
    check("R5 combined rdata at reset", c_rdata, 32'h0);
    for (int b = 0; b < 2; b++)
      for (int e = 0; e < NE; e++) begin
        for (int o = 0; o < ML; o++) begin
          @(negedge clk);
          ld_we = 1'b1; ld_bank = b[0]; ld_entry = e[2:0]; ld_off = o[3:0];
          ld_byte = (b != 0 ? 8'h80 : 8'h00) + 8'(e * 16 + o);
        end
        @(negedge clk);
        ld_we = 1'b0; ld_len_we = 1'b1; ld_len = 5'(item_len(b[0], e));
        @(negedge clk);
        ld_len_we = 1'b0;
      end
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      s_op(VEC[i].we, VEC[i].addr, VEC[i].size, VEC[i].wdata);
      if (!VEC[i].we)
        check($sformatf("R%0d vector %0d", VEC[i].req, i), s_rdata, VEC[i].exp);
    end

    // R5: reset in the middle of an item returns to item 0 at offset 0
    s_op(1'b1, 1'b0, 3'd2, 32'h0001);
    s_op(1'b0, 1'b1, 3'd1, 32'h0);
    check("R5 pre-reset read", s_rdata, 32'h10);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R5 rdata cleared by reset", s_rdata, 32'h0);
    s_op(1'b0, 1'b1, 3'd4, 32'h0);
    check("R5 item 0 after mid-run reset", s_rdata, 32'h00010203);

    // R9: combined window
    c_op(1'b0, 1'b0, 3'd1, 32'h0);
    check("R9 combined first byte", c_rdata, 32'h00000000);
    c_op(1'b0, 1'b0, 3'd1, 32'h0);
    check("R9 combined second byte", c_rdata, 32'h00000001);
    c_op(1'b1, 1'b0, 3'd2, 32'h8001);
    c_op(1'b0, 1'b0, 3'd1, 32'h0);
    check("R9 combined select", c_rdata, 32'h90);
    c_op(1'b0, 1'b1, 3'd1, 32'h0);
    check("R9 byte read at addr 1 rejected", c_rdata, 32'h0);
    c_op(1'b0, 1'b0, 3'd1, 32'h0);
    check("R9 no advance on reject", c_rdata, 32'h91);
    c_op(1'b0, 1'b0, 3'd2, 32'h0);
    check("R9 2-byte read rejected", c_rdata, 32'h0);
    c_op(1'b0, 1'b0, 3'd1, 32'h0);
    check("R9 continue after reject", c_rdata, 32'h92);
    c_op(1'b0, 1'b0, 3'd1, 32'h0);
    check("R4 combined exhausted", c_rdata, 32'h0);
    c_op(1'b1, 1'b0, 3'd1, 32'h55);
    c_op(1'b1, 1'b1, 3'd2, 32'h0001);
    c_op(1'b0, 1'b0, 3'd1, 32'h0);
    check("R9 select at addr 1", c_rdata, 32'h10);
    c_op(1'b1, 1'b0, 3'd4, 32'h0003);
    c_op(1'b0, 1'b0, 3'd1, 32'h0);
    check("R10 combined 4-byte write ignored", c_rdata, 32'h11);

    finish_run();
  end
endmodule